// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache

This block sits between a processor and a slower word-addressed memory. It holds a small number of lines. Each line has a valid flag, a tag and one data word. A line is selected by the low bits of the word address, and the remaining upper bits are the tag. On the processor side, a request is held until the ready signal is high in the same cycle. A read hit completes in the cycle it is presented. A read miss stalls the processor while the word is fetched and the line is filled.

Stores use a write-through policy. Each store updates (or allocates) its line at once and is also queued in a four-entry buffer. That buffer drains to memory by itself. A read miss waits until the buffer is empty, so memory never returns a stale word. Hit and miss totals are counted for every completed access.

Top module: `wt_cache`

## Requirements
- R1: After reset every line is invalid, both event counters read zero and no memory request is raised.
- R2: The line index is the word address modulo the number of lines (its low bits), and the upper bits are kept as the tag. An access whose index matches but whose tag differs evicts the old word, so a later access to the evicted address misses.
- R3: A read that hits raises ready in the cycle it is presented and returns the line's word, with no memory traffic of its own.
- R4: A read miss raises no memory read until the write buffer is empty. It then issues one read (write flag low) at the request address. It completes in the cycle the memory acknowledges, returning the memory word, and fills the line.
- R5: A write completes in the cycle it is presented when the buffer has a free slot. It writes the word into its line with the new tag and sets valid, so an immediate read of the same address hits and returns it.
- R6: Buffered writes reach memory in the order they were accepted, each with the write flag high. After a drain, memory holds the last value written to each address.
- R7: A write is stalled (ready low) while the buffer already holds four entries.
- R8: Each completed access increments exactly one of the hit and miss counters. A write counts as a hit when its line was valid with a matching tag. From an empty four-line cache, the reads 0,1,2,3,4,3,4,15 give 6 misses and 2 hits.
- R9: Once raised, a memory request keeps its address, data and write flag stable until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_rdata | output | DATA_W | Read data, valid with cpu_ready on reads |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = buffered write, 0 = line fill read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | One-cycle acknowledge from memory |
| mem_rdata | input | DATA_W | Memory read data, valid with mem_ack |
| hit_count | output | CNT_W | Completed hits |
| miss_count | output | CNT_W | Completed misses |

## Verification
Two things can fall in the same clock edge: the processor pushing a store into the buffer, and memory acknowledging the buffer head, which pops it. The bench provokes this with a burst of back-to-back stores against a memory that answers after several cycles, so pushes keep arriving while earlier entries retire. The result is judged by which store first sees a stall and by the final memory contents. A read miss issued right after buffered stores to the same address checks that the fill waits for the drain.

// File: rtl/wt_cache.sv
module wt_cache #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int LINES    = 4,
  parameter int WB_DEPTH = 4,
  parameter int CNT_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int PTR_W = $clog2(WB_DEPTH);
  localparam int OCC_W = PTR_W + 1;

  logic [LINES-1:0]  valid;
  logic [TAG_W-1:0]  tags  [LINES];
  logic [DATA_W-1:0] words [LINES];

  logic [ADDR_W-1:0] wb_addr [WB_DEPTH];
  logic [DATA_W-1:0] wb_data [WB_DEPTH];
  logic [PTR_W-1:0]  wb_rd, wb_wr;
  logic [OCC_W-1:0]  wb_cnt;

  logic              filling;
  logic [ADDR_W-1:0] fill_addr;

  wire [IDX_W-1:0] idx   = cpu_addr[IDX_W-1:0];
  wire [TAG_W-1:0] tag   = cpu_addr[ADDR_W-1:IDX_W];
  wire [IDX_W-1:0] f_idx = fill_addr[IDX_W-1:0];
  wire [TAG_W-1:0] f_tag = fill_addr[ADDR_W-1:IDX_W];
  wire hit      = valid[idx] && (tags[idx] == tag);
  wire wb_empty = (wb_cnt == '0);
  wire wb_full  = (wb_cnt == OCC_W'(WB_DEPTH));

  wire wr_go      = cpu_req && cpu_we && !filling && !wb_full;
  wire rd_hit     = cpu_req && !cpu_we && !filling && hit;
  wire fill_start = cpu_req && !cpu_we && !filling && !hit && wb_empty;
  wire fill_done  = filling && mem_ack;
  wire pop        = !filling && !wb_empty && mem_ack;

  assign cpu_ready = wr_go || rd_hit || fill_done;
  assign cpu_rdata = filling ? mem_rdata : words[idx];
  assign mem_req   = filling || !wb_empty;
  assign mem_we    = !filling;
  assign mem_addr  = filling ? fill_addr : wb_addr[wb_rd];
  assign mem_wdata = wb_data[wb_rd];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid      <= '0;
      wb_rd      <= '0;
      wb_wr      <= '0;
      wb_cnt     <= '0;
      filling    <= 1'b0;
      fill_addr  <= '0;
      hit_count  <= '0;
      miss_count <= '0;
      for (int i = 0; i < LINES; i++) begin
        tags[i]  <= '0;
        words[i] <= '0;
      end
      for (int i = 0; i < WB_DEPTH; i++) begin
        wb_addr[i] <= '0;
        wb_data[i] <= '0;
      end
    end else begin
      if (wr_go) begin
        valid[idx]     <= 1'b1;
        tags[idx]      <= tag;
        words[idx]     <= cpu_wdata;
        wb_addr[wb_wr] <= cpu_addr;
        wb_data[wb_wr] <= cpu_wdata;
        wb_wr          <= wb_wr + PTR_W'(1);
      end
      if (pop) wb_rd <= wb_rd + PTR_W'(1);
      case ({wr_go, pop})
        2'b10:   wb_cnt <= wb_cnt + OCC_W'(1);
        2'b01:   wb_cnt <= wb_cnt - OCC_W'(1);
        default: wb_cnt <= wb_cnt;
      endcase
      if (fill_start) begin
        filling   <= 1'b1;
        fill_addr <= cpu_addr;
      end
      if (fill_done) begin
        filling      <= 1'b0;
        valid[f_idx] <= 1'b1;
        tags[f_idx]  <= f_tag;
        words[f_idx] <= mem_rdata;
      end
      hit_count  <= hit_count  + CNT_W'(rd_hit || (wr_go && hit));
      miss_count <= miss_count + CNT_W'((wr_go && !hit) || fill_done);
    end
  end

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R4
  fill_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> (wb_cnt == '0));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_we && cpu_ready) |-> (wb_cnt < OCC_W'(WB_DEPTH)));

  // R8
  one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(hit_count) || $stable(miss_count));

  // R3
  hit_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_we && !filling && valid[idx] && tags[idx] == tag) |-> cpu_ready);
endmodule

// File: tb/wt_cache_bench.sv
`timescale 1ns/1ps
module wt_cache_bench;
  localparam int CLK_NS = 20;
  localparam int LAT    = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [7:0]  cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_ready;
  logic [31:0] cpu_rdata;
  logic        mem_req, mem_we, mem_ack;
  logic [7:0]  mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [15:0] hit_count, miss_count;

  int n_chk = 0, n_bad = 0;
  int lat_cnt;
  logic [31:0] bmem [256];

  wt_cache u_wt_cache (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .hit_count(hit_count), .miss_count(miss_count)
  );

  always #(CLK_NS/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0; mem_rdata <= '0; lat_cnt <= 0;
      for (int i = 0; i < 256; i++) bmem[i] <= 32'hA000_0000 + i;
    end else if (mem_ack) begin
      mem_ack <= 1'b0; lat_cnt <= 0;
    end else if (mem_req) begin
      if (lat_cnt == LAT) begin
        mem_ack <= 1'b1; lat_cnt <= 0;
        if (mem_we) bmem[mem_addr] <= mem_wdata;
        else mem_rdata <= bmem[mem_addr];
      end else lat_cnt <= lat_cnt + 1;
    end
  end

  // R9 monitor at the ports
  int   hold_bad = 0;
  logic p_req = 1'b0, p_ack = 1'b0, p_we = 1'b0;
  logic [7:0] p_addr = '0;
  always @(negedge clk) begin
    if (rst_n && p_req && !p_ack && (!mem_req || mem_addr !== p_addr || mem_we !== p_we))
      hold_bad++;
    p_req = mem_req; p_ack = mem_ack; p_addr = mem_addr; p_we = mem_we;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [7:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output int waits);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    waits = 0;
    #1;
    while (!cpu_ready) begin
      @(negedge clk); #1; waits++;
    end
    rd = cpu_rdata;
    @(posedge clk); #1;
    cpu_req = 1'b0;
  endtask

  // {expected hit, address}; read data expected = A0000000 + address
  localparam logic [8:0] VEC [9] = '{9'h000, 9'h001, 9'h002, 9'h003, 9'h004,
                                     9'h103, 9'h104, 9'h00F, 9'h000};

  initial begin
    logic [31:0] rd;
    int w;
    logic [15:0] h0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 hit_count", 32'(hit_count), 0);
    chk("R1 miss_count", 32'(miss_count), 0);
    chk("R1 mem_req", 32'(mem_req), 0);
    rst_n = 1'b1;

    for (int i = 0; i < 9; i++) begin
      h0 = hit_count;
      access(1'b0, VEC[i][7:0], 32'h0, rd, w);
      chk(VEC[i][8] ? "R3 hit data" : "R4 miss data", rd, 32'hA000_0000 + VEC[i][7:0]);
      chk("R2 R8 hit flag", 32'(hit_count - h0), 32'(VEC[i][8]));
      if (VEC[i][8]) chk("R3 zero wait", w, 0);
      if (i == 7) begin
        chk("R8 misses after sequence", 32'(miss_count), 6);
        chk("R8 hits after sequence", 32'(hit_count), 2);
      end
    end

    // write miss allocates, then read hits
    access(1'b1, 8'd5, 32'h5555_0001, rd, w);
    chk("R5 write zero wait", w, 0);
    chk("R8 write miss counted", 32'(miss_count), 8);
    access(1'b0, 8'd5, 32'h0, rd, w);
    chk("R5 read after write data", rd, 32'h5555_0001);
    chk("R5 read after write no wait", w, 0);
    repeat (20) @(posedge clk);
    #1;
    chk("R6 drained word", bmem[5], 32'h5555_0001);

    // burst: push and pop on the same edge, fifth write stalls
    for (int k = 0; k < 5; k++) begin
      access(1'b1, 8'd16 + 8'(k), 32'hB000_0000 + k, rd, w);
      if (k < 4) chk("R7 free slot no stall", w, 0);
      else chk("R7 full stalls", 32'(w > 0), 1);
    end
    repeat (40) @(posedge clk);
    #1;
    for (int k = 0; k < 5; k++) chk("R6 burst memory", bmem[16+k], 32'hB000_0000 + k);

    // read miss waits for buffered writes; same address written twice
    access(1'b1, 8'd30, 32'hC000_0001, rd, w);
    access(1'b1, 8'd30, 32'hC000_0002, rd, w);
    access(1'b1, 8'd24, 32'hC000_0024, rd, w);
    access(1'b1, 8'd28, 32'hC000_0028, rd, w);
    h0 = miss_count;
    access(1'b0, 8'd24, 32'h0, rd, w);
    chk("R4 fill sees buffered write", rd, 32'hC000_0024);
    chk("R2 evicted address misses", 32'(miss_count - h0), 1);
    repeat (20) @(posedge clk);
    #1;
    chk("R6 last value wins", bmem[30], 32'hC000_0002);
    chk("R6 later entry drained", bmem[28], 32'hC000_0028);
    chk("R9 request held until ack", hold_bad, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_NS * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule